// File: doc/BRIEF.md
# Per-Thread Commit Squash Controller

This block sits beside the reorder buffer of a multithreaded out-of-order core and decides, for each hardware thread, when that thread's in-flight work is thrown away. Three sources can cause a squash. A fault trap is taken and then fires after a programmable delay. A context-write request is held as a level. An execute-stage squash carries a sequence number and some flags. For each accepted squash the block announces the squash boundary, the restart PC and a one-cycle squash strobe toward the earlier pipeline stages. It then keeps the thread in a squashing state until the reorder buffer reports that its walk is finished.

The block also tracks the youngest surviving sequence number of each thread. It learns this number from the allocation stream that writes instructions into the reorder buffer. An execute squash that names an instruction younger than this number has already been overtaken by an older squash, so the block drops it. A trap or context-write squash flushes the whole thread.

The allocation input is a valid/ready stream for each thread. The block holds ready low while that thread is squashing, and the producer must keep valid and the sequence number steady until ready is high. A transfer takes place on any edge where valid and ready are both high. All other inputs are plain control levels or pulses, and none of them can be back-pressured.

Top module: `cmt_squash_ctrl`

## Requirements
- R1: Under reset, every thread reports status code 0 (idle), the strobes and squashing flags are low, the youngest number and the mispredict count are 0, and allocation ready is high.
- R2: An allocation transfer (valid and ready high) sets that thread's youngest number to the transferred sequence number on the same edge. Ready is low exactly while the thread's status is code 3 (reorder buffer squashing).
- R3: An execute squash is accepted only when its raw sequence number is less than or equal to the thread's youngest number. Otherwise it produces no strobe and leaves the youngest number unchanged.
- R4: An accepted execute squash raises the squash strobe for one cycle. It outputs the sequence number minus one if the include flag is set (unchanged otherwise), outputs the execute PC and mispredict flag, sets the youngest number to that output sequence, and moves the thread to code 3.
- R5: A thread in code 3 keeps its squashing flag high on every cycle until it samples the reorder buffer's done input. On that edge it moves to code 1 (running).
- R6: A trap taken on edge k puts the thread in code 2 (trap pending) and raises the trap squash strobe after edge k+L+1, where L is the trap latency input. A latency of 0 behaves like 1.
- R7: A trap or context-write squash outputs the head sequence number minus one, or 0 when the reorder buffer is empty. It outputs the thread's architectural PC, clears the mispredict flag, resets the youngest number to 0 and moves the thread to code 3.
- R8: The mispredict count rises by the number of threads that accept a mispredicting execute squash on the same edge. It is unchanged otherwise.
- R9: While a thread is in code 2, its execute squashes are ignored.
- R10: A new trap on a thread whose trap timer is running reloads the timer, so the squash lands L+1 edges after the newest trap.
- R11: When a whole-thread squash and an execute squash arrive on the same edge, the whole-thread squash alone takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_lat | input | LAT_W | Cycles from trap taken to trap squash |
| trap_take | input | NUM_THREADS | Trap taken, one bit per thread |
| ctx_req | input | NUM_THREADS | Context-write squash request (level) |
| exe_valid | input | NUM_THREADS | Execute-stage squash present |
| exe_seq | input | NUM_THREADS x SEQ_W | Execute squash sequence number |
| exe_incl | input | NUM_THREADS | Squash the named instruction as well |
| exe_mispred | input | NUM_THREADS | Execute squash is a branch mispredict |
| exe_pc | input | NUM_THREADS x PC_W | Execute squash redirect PC |
| arch_pc | input | NUM_THREADS x PC_W | Architectural restart PC per thread |
| rob_empty | input | NUM_THREADS | Reorder buffer holds nothing for the thread |
| rob_head_seq | input | NUM_THREADS x SEQ_W | Sequence number at the reorder buffer head |
| rob_done | input | NUM_THREADS | Reorder buffer finished its squash walk |
| alloc_valid | input | NUM_THREADS | Allocation stream valid |
| alloc_ready | output | NUM_THREADS | Allocation stream ready |
| alloc_seq | input | NUM_THREADS x SEQ_W | Allocated sequence number |
| sq_strobe | output | NUM_THREADS | One-cycle squash strobe |
| rob_squashing | output | NUM_THREADS | Thread is in its squash walk |
| sq_seq | output | NUM_THREADS x SEQ_W | Squash boundary sequence number |
| sq_pc | output | NUM_THREADS x PC_W | Redirect PC |
| sq_mispred | output | NUM_THREADS | Squash was a mispredict |
| youngest_seq | output | NUM_THREADS x SEQ_W | Youngest surviving sequence number |
| thr_status | output | NUM_THREADS x 2 | 0 idle, 1 running, 2 trap pending, 3 squashing |
| mispred_cnt | output | CNT_W | Accepted mispredict count |

## Verification
The bench builds the block with two threads, 8-bit sequence numbers, 16-bit PCs, a 4-bit latency field and a 6-bit counter. With two threads it can show that one thread's trap window leaves the other alone, and that two mispredicts on the same edge add two to the count. The narrow latency field lets a reloaded trap timer be followed edge by edge. The small sequence width keeps the filter boundary, where the number equals the youngest, easy to hit.

// File: rtl/cmt_sq_pkg.sv
package cmt_sq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_TRAP  = 2'd2,
    ST_ROBSQ = 2'd3
  } thr_state_e;
endpackage

// File: rtl/cmt_trap_timer.sv
module cmt_trap_timer #(
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W-1:0] lat,
  output logic             fire
);
  logic [LAT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fire   <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= lat;
      end else if (busy_q) begin
        if (cnt_q <= LAT_W'(1)) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
          fire   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - LAT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cmt_squash_thread.sv
module cmt_squash_thread
  import cmt_sq_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_take,
  input  logic             trap_fire,
  input  logic             ctx_req,
  input  logic             exe_valid,
  input  logic [SEQ_W-1:0] exe_seq,
  input  logic             exe_incl,
  input  logic             exe_mispred,
  input  logic [PC_W-1:0]  exe_pc,
  input  logic [PC_W-1:0]  arch_pc,
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] rob_head_seq,
  input  logic             rob_done,
  input  logic             alloc_valid,
  input  logic [SEQ_W-1:0] alloc_seq,
  output logic             alloc_ready,
  output logic             sq_strobe,
  output logic             rob_squashing,
  output logic [SEQ_W-1:0] sq_seq,
  output logic [PC_W-1:0]  sq_pc,
  output logic             sq_mispred,
  output logic [SEQ_W-1:0] youngest,
  output logic [1:0]       status,
  output logic             mis_event
);
  thr_state_e       st_q;
  logic             full_sq;
  logic             exe_ok;
  logic [SEQ_W-1:0] full_seq;
  logic [SEQ_W-1:0] exe_eff;

  always_comb begin
    full_sq   = trap_fire | ctx_req;
    full_seq  = rob_empty ? '0 : rob_head_seq - SEQ_W'(1);
    exe_eff   = exe_seq - SEQ_W'(exe_incl);
    exe_ok    = exe_valid && (st_q != ST_TRAP) && (exe_seq <= youngest) && !full_sq;
    mis_event = exe_ok && exe_mispred;
  end

  assign alloc_ready   = (st_q != ST_ROBSQ);
  assign rob_squashing = (st_q == ST_ROBSQ);
  assign status        = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sq_strobe  <= 1'b0;
      sq_seq     <= '0;
      sq_pc      <= '0;
      sq_mispred <= 1'b0;
      youngest   <= '0;
    end else begin
      sq_strobe <= full_sq | exe_ok;
      if (full_sq) begin
        sq_seq     <= full_seq;
        sq_pc      <= arch_pc;
        sq_mispred <= 1'b0;
        youngest   <= '0;
        st_q       <= ST_ROBSQ;
      end else if (exe_ok) begin
        sq_seq     <= exe_eff;
        sq_pc      <= exe_pc;
        sq_mispred <= exe_mispred;
        youngest   <= exe_eff;
        st_q       <= ST_ROBSQ;
      end else begin
        if (alloc_valid && alloc_ready) youngest <= alloc_seq;
        if (st_q == ST_ROBSQ && rob_done) st_q <= ST_RUN;
      end
      if (trap_take) st_q <= ST_TRAP;
    end
  end
endmodule

// File: rtl/cmt_mispred_counter.sv
module cmt_mispred_counter #(
  parameter int N     = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     events,
  output logic [CNT_W-1:0] count
);
  localparam int INC_W = $clog2(N + 1);
  logic [INC_W-1:0] inc;

  always_comb begin
    inc = '0;
    for (int i = 0; i < N; i++) inc = inc + INC_W'(events[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + CNT_W'(inc);
  end
endmodule

// File: rtl/cmt_squash_ctrl.sv
module cmt_squash_ctrl #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int PC_W        = 32,
  parameter int LAT_W       = 6,
  parameter int CNT_W       = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [LAT_W-1:0]                    trap_lat,
  input  logic [NUM_THREADS-1:0]              trap_take,
  input  logic [NUM_THREADS-1:0]              ctx_req,
  input  logic [NUM_THREADS-1:0]              exe_valid,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   exe_seq,
  input  logic [NUM_THREADS-1:0]              exe_incl,
  input  logic [NUM_THREADS-1:0]              exe_mispred,
  input  logic [NUM_THREADS-1:0][PC_W-1:0]    exe_pc,
  input  logic [NUM_THREADS-1:0][PC_W-1:0]    arch_pc,
  input  logic [NUM_THREADS-1:0]              rob_empty,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   rob_head_seq,
  input  logic [NUM_THREADS-1:0]              rob_done,
  input  logic [NUM_THREADS-1:0]              alloc_valid,
  output logic [NUM_THREADS-1:0]              alloc_ready,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   alloc_seq,
  output logic [NUM_THREADS-1:0]              sq_strobe,
  output logic [NUM_THREADS-1:0]              rob_squashing,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   sq_seq,
  output logic [NUM_THREADS-1:0][PC_W-1:0]    sq_pc,
  output logic [NUM_THREADS-1:0]              sq_mispred,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   youngest_seq,
  output logic [NUM_THREADS-1:0][1:0]         thr_status,
  output logic [CNT_W-1:0]                    mispred_cnt
);
  logic [NUM_THREADS-1:0] trap_fire;
  logic [NUM_THREADS-1:0] mis_event;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    cmt_trap_timer #(.LAT_W(LAT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (trap_take[t]),
      .lat   (trap_lat),
      .fire  (trap_fire[t])
    );

    cmt_squash_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_thr (
      .clk           (clk),
      .rst_n         (rst_n),
      .trap_take     (trap_take[t]),
      .trap_fire     (trap_fire[t]),
      .ctx_req       (ctx_req[t]),
      .exe_valid     (exe_valid[t]),
      .exe_seq       (exe_seq[t]),
      .exe_incl      (exe_incl[t]),
      .exe_mispred   (exe_mispred[t]),
      .exe_pc        (exe_pc[t]),
      .arch_pc       (arch_pc[t]),
      .rob_empty     (rob_empty[t]),
      .rob_head_seq  (rob_head_seq[t]),
      .rob_done      (rob_done[t]),
      .alloc_valid   (alloc_valid[t]),
      .alloc_seq     (alloc_seq[t]),
      .alloc_ready   (alloc_ready[t]),
      .sq_strobe     (sq_strobe[t]),
      .rob_squashing (rob_squashing[t]),
      .sq_seq        (sq_seq[t]),
      .sq_pc         (sq_pc[t]),
      .sq_mispred    (sq_mispred[t]),
      .youngest      (youngest_seq[t]),
      .status        (thr_status[t]),
      .mis_event     (mis_event[t])
    );
  end

  cmt_mispred_counter #(.N(NUM_THREADS), .CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .events (mis_event),
    .count  (mispred_cnt)
  );
endmodule

// File: rtl/cmt_squash_ctrl_chk.sv
module cmt_squash_ctrl_chk #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  parameter int CNT_W       = 16
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_THREADS-1:0]            trap_take,
  input logic [NUM_THREADS-1:0]            trap_fire,
  input logic [NUM_THREADS-1:0]            ctx_req,
  input logic [NUM_THREADS-1:0]            exe_valid,
  input logic [NUM_THREADS-1:0][SEQ_W-1:0] exe_seq,
  input logic [NUM_THREADS-1:0]            rob_done,
  input logic [NUM_THREADS-1:0]            sq_strobe,
  input logic [NUM_THREADS-1:0]            rob_squashing,
  input logic [NUM_THREADS-1:0][SEQ_W-1:0] youngest_seq,
  input logic [NUM_THREADS-1:0][1:0]       thr_status,
  input logic [CNT_W-1:0]                  mispred_cnt
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    AST_STALE_EXE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (exe_valid[t] && exe_seq[t] > youngest_seq[t] && !ctx_req[t] && !trap_fire[t])
      |=> !sq_strobe[t]); // R3

    AST_TRAP_BLOCKS_EXE: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_status[t] == 2'd2 && !trap_fire[t] && !ctx_req[t]) |=> !sq_strobe[t]); // R9

    AST_TRAP_FULL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_fire[t] && !trap_take[t])
      |=> (sq_strobe[t] && youngest_seq[t] == '0 && rob_squashing[t])); // R7

    AST_SQUASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_squashing[t] && !rob_done[t] && !trap_take[t]) |=> rob_squashing[t]); // R5
  end

  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_strobe == '0) |-> $stable(mispred_cnt)); // R8
endmodule

bind cmt_squash_ctrl cmt_squash_ctrl_chk #(
  .NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .trap_take     (trap_take),
  .trap_fire     (trap_fire),
  .ctx_req       (ctx_req),
  .exe_valid     (exe_valid),
  .exe_seq       (exe_seq),
  .rob_done      (rob_done),
  .sq_strobe     (sq_strobe),
  .rob_squashing (rob_squashing),
  .youngest_seq  (youngest_seq),
  .thr_status    (thr_status),
  .mispred_cnt   (mispred_cnt)
);

// File: tb/cmt_squash_ctrl_test.sv
module cmt_squash_ctrl_test;
  localparam int T = 2, SW = 8, PW = 16, LW = 4, CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LW-1:0] trap_lat;
  logic [T-1:0] trap_take, ctx_req, exe_valid, exe_incl, exe_mispred;
  logic [T-1:0][SW-1:0] exe_seq, rob_head_seq, alloc_seq;
  logic [T-1:0][PW-1:0] exe_pc, arch_pc;
  logic [T-1:0] rob_empty, rob_done, alloc_valid, alloc_ready;
  logic [T-1:0] sq_strobe, rob_squashing, sq_mispred;
  logic [T-1:0][SW-1:0] sq_seq, youngest_seq;
  logic [T-1:0][PW-1:0] sq_pc;
  logic [T-1:0][1:0] thr_status;
  logic [CW-1:0] mispred_cnt;

  int n_chk = 0, n_bad = 0, exp_cnt = 0;

  always #5 clk = ~clk;

  cmt_squash_ctrl #(.NUM_THREADS(T), .SEQ_W(SW), .PC_W(PW), .LAT_W(LW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .trap_lat(trap_lat), .trap_take(trap_take),
    .ctx_req(ctx_req), .exe_valid(exe_valid), .exe_seq(exe_seq), .exe_incl(exe_incl),
    .exe_mispred(exe_mispred), .exe_pc(exe_pc), .arch_pc(arch_pc), .rob_empty(rob_empty),
    .rob_head_seq(rob_head_seq), .rob_done(rob_done), .alloc_valid(alloc_valid),
    .alloc_ready(alloc_ready), .alloc_seq(alloc_seq), .sq_strobe(sq_strobe),
    .rob_squashing(rob_squashing), .sq_seq(sq_seq), .sq_pc(sq_pc), .sq_mispred(sq_mispred),
    .youngest_seq(youngest_seq), .thr_status(thr_status), .mispred_cnt(mispred_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    trap_take = '0; ctx_req = '0; exe_valid = '0; exe_incl = '0; exe_mispred = '0;
    rob_done = '0; alloc_valid = '0;
  endtask

  task automatic finish_sq(input int t);
    rob_done[t] = 1'b1;
    tick();
    rob_done[t] = 1'b0;
  endtask

  task automatic alloc(input int t, input int s);
    alloc_valid[t] = 1'b1; alloc_seq[t] = SW'(s);
    tick();
    alloc_valid[t] = 1'b0;
    chk("R2", "youngest after alloc", youngest_seq[t], s);
  endtask

  task automatic t_reset();
    for (int t = 0; t < T; t++) begin
      chk("R1", "status", thr_status[t], 0);
      chk("R1", "strobe", sq_strobe[t], 0);
      chk("R1", "squashing", rob_squashing[t], 0);
      chk("R1", "youngest", youngest_seq[t], 0);
      chk("R1", "ready", alloc_ready[t], 1);
    end
    chk("R1", "count", mispred_cnt, 0);
  endtask

  task automatic t_exe_accept();
    alloc(0, 20);
    exe_valid[0] = 1; exe_seq[0] = 15; exe_mispred[0] = 1; exe_pc[0] = 16'h1234;
    tick();
    quiet();
    exp_cnt++;
    chk("R4", "strobe", sq_strobe[0], 1);
    chk("R4", "seq", sq_seq[0], 15);
    chk("R4", "pc", sq_pc[0], 16'h1234);
    chk("R4", "mispred", sq_mispred[0], 1);
    chk("R4", "youngest", youngest_seq[0], 15);
    chk("R4", "status", thr_status[0], 3);
    chk("R2", "ready low while squashing", alloc_ready[0], 0);
    chk("R8", "count", mispred_cnt, exp_cnt);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5", "held squashing", rob_squashing[0], 1);
      chk("R4", "strobe one cycle", sq_strobe[0], 0);
    end
    finish_sq(0);
    chk("R5", "status after done", thr_status[0], 1);
    chk("R5", "squashing cleared", rob_squashing[0], 0);
    chk("R2", "ready restored", alloc_ready[0], 1);
  endtask

  task automatic t_filter();
    exe_valid[0] = 1; exe_seq[0] = 16; exe_mispred[0] = 1;
    tick();
    quiet();
    chk("R3", "younger squash strobe", sq_strobe[0], 0);
    chk("R3", "younger squash youngest", youngest_seq[0], 15);
    chk("R3", "younger squash count", mispred_cnt, exp_cnt);
    exe_valid[0] = 1; exe_seq[0] = 15; exe_incl[0] = 1; exe_pc[0] = 16'h0abc;
    tick();
    quiet();
    chk("R3", "equal squash accepted", sq_strobe[0], 1);
    chk("R4", "include seq", sq_seq[0], 14);
    chk("R4", "include youngest", youngest_seq[0], 14);
    chk("R4", "no mispred", sq_mispred[0], 0);
    finish_sq(0);
  endtask

  task automatic t_trap();
    alloc(1, 30);
    trap_lat = 3; rob_empty[1] = 0; rob_head_seq[1] = 50; arch_pc[1] = 16'h4000;
    trap_take[1] = 1;
    tick();
    quiet();
    chk("R6", "trap pending", thr_status[1], 2);
    chk("R6", "no strobe E0", sq_strobe[1], 0);
    exe_valid[1] = 1; exe_seq[1] = 5; exe_mispred[1] = 1;
    tick();
    quiet();
    chk("R9", "exe ignored strobe", sq_strobe[1], 0);
    chk("R9", "exe ignored youngest", youngest_seq[1], 30);
    chk("R9", "exe ignored count", mispred_cnt, exp_cnt);
    tick();
    chk("R6", "no strobe E2", sq_strobe[1], 0);
    tick();
    chk("R6", "no strobe E3", sq_strobe[1], 0);
    tick();
    chk("R6", "strobe at L+1", sq_strobe[1], 1);
    chk("R7", "seq head-1", sq_seq[1], 49);
    chk("R7", "pc", sq_pc[1], 16'h4000);
    chk("R7", "youngest reset", youngest_seq[1], 0);
    chk("R7", "status", thr_status[1], 3);
    chk("R7", "mispred clear", sq_mispred[1], 0);
    chk("R7", "thread0 untouched", sq_strobe[0], 0);
    tick();
    chk("R6", "strobe single", sq_strobe[1], 0);
    finish_sq(1);
  endtask

  task automatic t_restart();
    trap_lat = 4;
    trap_take[0] = 1;
    tick();
    trap_take[0] = 0;
    tick();
    trap_take[0] = 1;
    tick();
    trap_take[0] = 0;
    for (int e = 3; e <= 6; e++) begin
      tick();
      chk("R10", "no early strobe", sq_strobe[0], 0);
    end
    tick();
    chk("R10", "strobe after reload", sq_strobe[0], 1);
    finish_sq(0);
  endtask

  task automatic t_ctx();
    rob_empty[0] = 1; arch_pc[0] = 16'h2222;
    ctx_req[0] = 1;
    tick();
    quiet();
    chk("R7", "ctx strobe", sq_strobe[0], 1);
    chk("R7", "ctx empty seq", sq_seq[0], 0);
    chk("R7", "ctx pc", sq_pc[0], 16'h2222);
    finish_sq(0);
  endtask

  task automatic t_both();
    alloc(0, 40);
    rob_empty[0] = 0; rob_head_seq[0] = 33; arch_pc[0] = 16'h3333;
    ctx_req[0] = 1;
    exe_valid[0] = 1; exe_seq[0] = 10; exe_mispred[0] = 1; exe_pc[0] = 16'h7777;
    tick();
    quiet();
    chk("R11", "seq from head", sq_seq[0], 32);
    chk("R11", "pc arch", sq_pc[0], 16'h3333);
    chk("R11", "youngest", youngest_seq[0], 0);
    chk("R11", "count", mispred_cnt, exp_cnt);
    finish_sq(0);
  endtask

  task automatic t_dual();
    alloc(0, 60);
    alloc(1, 60);
    for (int t = 0; t < T; t++) begin
      exe_valid[t] = 1; exe_seq[t] = 55; exe_mispred[t] = 1;
    end
    tick();
    quiet();
    exp_cnt += 2;
    chk("R8", "dual count", mispred_cnt, exp_cnt);
    finish_sq(0);
    finish_sq(1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    quiet();
    trap_lat = 0; exe_seq = '0; exe_pc = '0; arch_pc = '0; rob_empty = '1;
    rob_head_seq = '0; alloc_seq = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_exe_accept();
    t_filter();
    t_trap();
    t_restart();
    t_ctx();
    t_both();
    t_dual();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule